// File: doc/BRIEF.md
# Fractional Baud-Rate Enable Generator

This block produces the two timing strobes a serial transmitter and receiver need: a sampling enable at the oversampled rate, and a bit-rate enable. Both are one-clock enables in the main clock domain. A two-bit selector picks the source of input ticks. The choices are every main clock, a fixed prescaled tick, or an external tick that is already synchronized to the main clock. A fourth code is reserved.

In asynchronous mode the tick stream is divided by a 16-bit integer plus a 3-bit fraction in eighths. Some divider periods are stretched by one tick so that the average rate is exact. The sampling strobe is then divided by 16 or 8 to give the bit rate. In synchronous mode the fraction and the oversampling divide are both bypassed, and each strobe fires once every integer-divisor ticks.

A new divisor, fraction or oversampling choice is taken up only at a period boundary, so a period in progress is never cut short.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high, `samp_en` and `baud_en` are low.
- R2: In asynchronous mode with `frac=0` and source code 0 (every clock), `samp_en` pulses once every `div_int` clocks.
- R3: In asynchronous mode with non-zero `frac`, every interval between `samp_en` pulses is `div_int` or `div_int+1` ticks. Any 8 consecutive intervals add up to exactly 8·`div_int`+`frac` ticks.
- R4: In asynchronous mode, `baud_en` pulses once per 16 `samp_en` pulses when `os8=0`, and once per 8 when `os8=1`.
- R5: With `sync_mode=1`, both `samp_en` and `baud_en` pulse every `div_int` ticks, and `frac` and `os8` have no effect.
- R6: Source code 1 supplies one tick every `PRE_DIV` clocks (default 8).
- R7: Source code 3 supplies one tick for each clock in which `ext_tick` is high.
- R8: Source code 2 is reserved and produces no pulses on either output.
- R9: While `div_int` is 0, both outputs stay low and the dividers are held at their reset state.
- R10: A change of `div_int` takes effect only at the next `samp_en` pulse. The interval in progress keeps its old length.
- R11: `baud_en` in asynchronous mode is never high on two consecutive clocks, and `samp_en` is never high on two consecutive clocks when `div_int` ≥ 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Tick source: 0 every clock, 1 prescaled, 2 reserved, 3 external |
| ext_tick | input | 1 | External tick, already synchronized to `clk` |
| div_int | input | 16 | Integer divisor |
| frac | input | 3 | Fraction in eighths added to the divisor (asynchronous mode) |
| os8 | input | 1 | 0: oversample by 16, 1: oversample by 8 |
| sync_mode | input | 1 | 1 selects synchronous mode (integer divide only) |
| samp_en | output | 1 | Sampling-rate enable strobe |
| baud_en | output | 1 | Bit-rate enable strobe |

## Verification
`samp_en` is registered. It rises on the clock after the tick that ends a period. `baud_en` passes through one more register and follows the matching `samp_en` by one clock. Because every delay is fixed, the checks compare the gaps between pulses rather than absolute times. Outputs are sampled on the falling edge, and each gap is counted in main-clock cycles. For the divisor-change check, the new value is applied on the falling edge of the cycle in which a pulse is seen, after the reload edge. The next gap must therefore still show the old length.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 3;

  typedef enum logic [1:0] {
    SRC_CORE  = 2'd0,
    SRC_PRESC = 2'd1,
    SRC_RSVD  = 2'd2,
    SRC_EXT   = 2'd3
  } src_e;
endpackage

// File: rtl/fbg_src_sel.sv
module fbg_src_sel
  import fbg_pkg::*;
#(
  parameter int PRE_DIV = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       ext_tick,
  output logic       tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pcnt;
  logic          pre_tick;

  assign pre_tick = (pcnt == PLAST);

  always_ff @(posedge clk) begin
    if (rst) pcnt <= '0;
    else if (pre_tick) pcnt <= '0;
    else pcnt <= pcnt + 1'b1;
  end

  always_comb begin
    unique case (src_e'(sel))
      SRC_CORE:  tick = 1'b1;
      SRC_PRESC: tick = pre_tick;
      SRC_EXT:   tick = ext_tick;
      default:   tick = 1'b0;
    endcase
  end

  // R8: reserved code never forwards a tick
  p_rsvd_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_RSVD) |-> !tick);
endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] frac,
  input  logic              frac_en,
  output logic              pulse
);
  logic [INT_W:0]    cnt;
  logic [INT_W-1:0]  div_q;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic              term;
  logic              hold;

  assign hold = (div_int == '0);
  assign term = (cnt <= 1);

  always_comb begin
    sum = {1'b0, acc} + {1'b0, (frac_en ? frac : '0)};
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt   <= '0;
      acc   <= '0;
      div_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (term) begin
          acc   <= sum[FRAC_W-1:0];
          cnt   <= {1'b0, div_int} + {{INT_W{1'b0}}, sum[FRAC_W]};
          div_q <= div_int;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R3: a reload is the latched divisor or one more, never anything else
  p_reload_range_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && term && !hold) |=>
      (hold || cnt == {1'b0, div_q} || cnt == {1'b0, div_q} + 1'b1));

  // R5: in integer-only mode the phase accumulator does not move
  p_frac_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && term && !hold && !frac_en) |=> (hold || $stable(acc)));
endmodule

// File: rtl/fbg_over_div.sv
module fbg_over_div (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic samp,
  input  logic os8,
  input  logic sync_mode,
  output logic baud
);
  localparam int OW = 4;
  localparam logic [OW-1:0] LAST16 = OW'(15);
  localparam logic [OW-1:0] LAST8  = OW'(7);

  logic [OW-1:0] ocnt;
  logic          os8_q;
  logic [OW-1:0] last;

  assign last = os8_q ? LAST8 : LAST16;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ocnt  <= '0;
      os8_q <= os8;
      baud  <= 1'b0;
    end else begin
      baud <= 1'b0;
      if (samp) begin
        if (sync_mode) begin
          baud <= 1'b1;
        end else if (ocnt == last) begin
          ocnt  <= '0;
          os8_q <= os8;
          baud  <= 1'b1;
        end else begin
          ocnt <= ocnt + 1'b1;
        end
      end
    end
  end

  // R11: the oversampled bit strobe is one clock wide
  p_baud_single_r11: assert property (@(posedge clk) disable iff (rst)
    (baud && !sync_mode) |=> !baud);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int PRE_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        src_sel,
  input  logic              ext_tick,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] frac,
  input  logic              os8,
  input  logic              sync_mode,
  output logic              samp_en,
  output logic              baud_en
);
  logic tick;
  logic div_zero;

  assign div_zero = (div_int == '0);

  fbg_src_sel #(.PRE_DIV(PRE_DIV)) u_src (
    .clk      (clk),
    .rst      (rst),
    .sel      (src_sel),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  fbg_frac_div u_frac (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .div_int (div_int),
    .frac    (frac),
    .frac_en (!sync_mode),
    .pulse   (samp_en)
  );

  fbg_over_div u_over (
    .clk       (clk),
    .rst       (rst),
    .clr       (div_zero),
    .samp      (samp_en),
    .os8       (os8),
    .sync_mode (sync_mode),
    .baud      (baud_en)
  );

  // R9: a zero divisor silences both strobes
  p_zero_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    div_zero |=> (!samp_en && !baud_en));

  // R1: reset clears both strobes
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!samp_en && !baud_en));
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_sel = 2'd0;
  logic        ext_tick = 1'b0;
  logic [15:0] div_int = 16'd4;
  logic [2:0]  frac = 3'd0;
  logic        os8 = 1'b0;
  logic        sync_mode = 1'b0;
  logic        samp_en, baud_en;

  int cyc = 0, total = 0, bad = 0;
  int s_cnt = 0, b_cnt = 0, dbl = 0;
  int ext_period = 3;
  logic ps = 1'b0, pb = 1'b0;

  always #2 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst(rst), .src_sel(src_sel), .ext_tick(ext_tick),
    .div_int(div_int), .frac(frac), .os8(os8), .sync_mode(sync_mode),
    .samp_en(samp_en), .baud_en(baud_en)
  );

  initial forever begin
    @(posedge clk);
    cyc = cyc + 1;
  end

  // R11 monitor: consecutive-high strobes, and pulse counts for quiet windows
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (samp_en) s_cnt = s_cnt + 1;
      if (baud_en) b_cnt = b_cnt + 1;
      if (baud_en && pb && !sync_mode) dbl = dbl + 1;
      if (samp_en && ps && div_int >= 16'd2) dbl = dbl + 1;
    end
    ps = samp_en;
    pb = baud_en;
  end

  // external tick source driven away from the active edge
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1 >= ext_period) ? 0 : k + 1;
      ext_tick = (k == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic next_samp(output int t);
    do @(negedge clk); while (!samp_en);
    t = cyc;
  endtask

  task automatic next_baud(output int t);
    do @(negedge clk); while (!baud_en);
    t = cyc;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 samp_en in reset", int'(samp_en), 0);
    check("R1 baud_en in reset", int'(baud_en), 0);
  endtask

  task automatic t_integer();
    int a, b, c;
    src_sel = 2'd0; div_int = 16'd4; frac = 3'd0; os8 = 1'b0; sync_mode = 1'b0;
    do_reset();
    next_samp(a); next_samp(b); next_samp(c);
    check("R2 interval 1", b - a, 4);
    check("R2 interval 2", c - b, 4);
    next_baud(a); next_baud(b);
    check("R4 os16 baud period", b - a, 64);
  endtask

  task automatic t_fraction();
    int t[9];
    int a, b;
    src_sel = 2'd0; div_int = 16'd4; frac = 3'd3; os8 = 1'b0; sync_mode = 1'b0;
    do_reset();
    foreach (t[i]) next_samp(t[i]);
    for (int i = 1; i < 9; i++) begin
      int d = t[i] - t[i-1];
      check("R3 interval in {4,5}", (d == 4 || d == 5) ? 1 : 0, 1);
    end
    check("R3 sum of 8 intervals", t[8] - t[0], 35);
    next_baud(a); next_baud(b);
    check("R4 os16 fractional baud period", b - a, 70);
  endtask

  task automatic t_os8();
    int a, b;
    src_sel = 2'd0; div_int = 16'd4; frac = 3'd0; os8 = 1'b1; sync_mode = 1'b0;
    do_reset();
    next_baud(a); next_baud(b);
    check("R4 os8 baud period", b - a, 32);
  endtask

  task automatic t_sync();
    int a, b, c;
    src_sel = 2'd0; div_int = 16'd5; frac = 3'd3; os8 = 1'b0; sync_mode = 1'b1;
    do_reset();
    next_samp(a); next_samp(b); next_samp(c);
    check("R5 sync samp interval 1", b - a, 5);
    check("R5 sync samp interval 2", c - b, 5);
    next_baud(a); next_baud(b);
    check("R5 sync baud period", b - a, 5);
    sync_mode = 1'b0;
  endtask

  task automatic t_presc();
    int a, b, c;
    src_sel = 2'd1; div_int = 16'd2; frac = 3'd0; os8 = 1'b0; sync_mode = 1'b0;
    do_reset();
    next_samp(a); next_samp(b); next_samp(c);
    check("R6 prescaled interval 1", b - a, 16);
    check("R6 prescaled interval 2", c - b, 16);
  endtask

  task automatic t_ext();
    int a, b, c;
    src_sel = 2'd3; ext_period = 3; div_int = 16'd2; frac = 3'd0; sync_mode = 1'b0;
    do_reset();
    next_samp(a); next_samp(b); next_samp(c);
    check("R7 external interval 1", b - a, 6);
    check("R7 external interval 2", c - b, 6);
  endtask

  task automatic t_rsvd();
    src_sel = 2'd2; div_int = 16'd2; frac = 3'd0; sync_mode = 1'b0;
    do_reset();
    s_cnt = 0; b_cnt = 0;
    repeat (300) @(negedge clk);
    check("R8 reserved samp pulses", s_cnt, 0);
    check("R8 reserved baud pulses", b_cnt, 0);
  endtask

  task automatic t_zero();
    src_sel = 2'd0; div_int = 16'd0; frac = 3'd5; sync_mode = 1'b0;
    do_reset();
    s_cnt = 0; b_cnt = 0;
    repeat (300) @(negedge clk);
    check("R9 zero divisor samp pulses", s_cnt, 0);
    check("R9 zero divisor baud pulses", b_cnt, 0);
  endtask

  task automatic t_update();
    int a, b, c;
    src_sel = 2'd0; div_int = 16'd10; frac = 3'd0; sync_mode = 1'b0;
    do_reset();
    next_samp(a); next_samp(a);
    div_int = 16'd3;
    next_samp(b); next_samp(c);
    check("R10 running interval keeps old length", b - a, 10);
    check("R10 next interval uses new divisor", c - b, 3);
  endtask

  initial begin
    t_reset();
    t_integer();
    t_fraction();
    t_os8();
    t_sync();
    t_presc();
    t_ext();
    t_rsvd();
    t_zero();
    t_update();
    check("R11 no double-wide strobes", dbl, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule